// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block is the digital side of a 14-bit successive-approximation converter, seen from the converter. A low level on the convert-start input begins a conversion. The block captures the sample word offered on an abstract input port at that moment. It pulls the busy flag low for the length of the conversion and sends the result one bit at a time on a single data line. A free-running internal clock paces the conversion. That clock is also driven on a pin, so a host can latch bits that leave while the conversion is still running.

Two mode inputs give four ways to read the result. The first picks the shift clock: the internal clock or a host-supplied external clock. The second picks when shifting happens: during the conversion, or after it. In the after-conversion mode the word waits inside the block until the host pulls the read input low. A two-bit power input selects run, nap or sleep. In nap the stored word can still be read. In sleep every logic output is released. High impedance is modelled by output-enable signals placed next to the data they qualify.

Top module: `adc_serial_if`

## Requirements
- R1: While reset is asserted, busy_n is 1, sdo is 0 and clkout is 0.
- R2: With conv_n low, busy_n high and pwr_mode 00, busy_n goes low at the next clock edge. It returns high at the 14th rising edge of clkout after that start.
- R3: conv_n low while busy_n is low is ignored. The conversion length and the captured word are unchanged.
- R4: The captured word appears on sdo most-significant bit first. Each shift event advances one bit. After 14 shifts, sdo stays 0 until the next conversion.
- R5: With clk_sel 0, shift events are the rising edges of clkout.
- R6: With clk_sel 1, shift events are rising edges of ext_sclk. Such an edge takes effect at the third clock edge that samples ext_sclk high.
- R7: With after_mode 0, shifting happens only while busy_n is low. With after_mode 1, shifting happens only while busy_n is high and rd_n is low, and the word is held until then.
- R8: pwr_mode 01 (nap) starts no conversion. Readout keeps working in nap, and the last word can still be read.
- R9: pwr_mode 1x (sleep) drives sdo_oe and ctl_oe low, starts no conversion and does not shift. The stored word survives sleep.
- R10: sdo_oe is 1 exactly when rd_n is 0 and the block is not in sleep. ctl_oe is 1 exactly when the block is not in sleep.
- R11: clkout toggles every DIV clock cycles in every mode (DIV = 2 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n | input | 1 | Convert start, active low |
| rd_n | input | 1 | Read enable, active low; gates the data output and after-conversion shifting |
| pwr_mode | input | 2 | 00 run, 01 nap, 1x sleep |
| clk_sel | input | 1 | 0: internal shift clock, 1: external shift clock |
| after_mode | input | 1 | 0: shift during conversion, 1: shift after conversion on read |
| ext_sclk | input | 1 | External shift clock (asynchronous) |
| sample_i | input | 14 | Sample word captured at conversion start |
| busy_n | output | 1 | Low while converting |
| clkout | output | 1 | Free-running internal clock |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Drive enable for sdo |
| ctl_oe | output | 1 | Drive enable for busy_n and clkout |

## Verification
The checker tests four things on every cycle. A busy period starts only after a low convert-start seen in run mode. Sleep releases both enables. A high read input releases the data line. clkout keeps its fixed toggle spacing. It also shows that, in after-conversion mode, the data line cannot move while read is high and no start is requested. Other properties need whole sequences and come from the bench's scenarios. These are the bit order of a complete word under each clock source, the retention of a word across nap and sleep, and the rejection of a start that arrives mid-conversion.

// File: rtl/adc_serial_if_pkg.sv
package adc_serial_if_pkg;
  localparam int unsigned SAMPLE_W = 14;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'b00,
    PWR_NAP   = 2'b01,
    PWR_SLEEP = 2'b10
  } pwr_e;

  function automatic logic pwr_is_sleep(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic pwr_is_run(input logic [1:0] m);
    return (m == PWR_RUN);
  endfunction
endpackage

// File: rtl/adc_clkgen.sv
module adc_clkgen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic clkout,
  output logic rise_tick
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q, div_d;
  logic          clk_q, clk_d;
  logic          tick;

  always_comb begin
    tick      = (div_q == DW'(DIV - 1));
    div_d     = tick ? '0 : div_q + 1'b1;
    clk_d     = clk_q ^ tick;
    rise_tick = tick & ~clk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      clk_q <= 1'b0;
    end else begin
      div_q <= div_d;
      clk_q <= clk_d;
    end
  end

  assign clkout = clk_q;
endmodule

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], async_in};
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int unsigned W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic run_ok,
  input  logic rise_tick,
  output logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] left_q, left_d;

  always_comb begin
    start  = start_req & ~busy_q & run_ok;
    busy_d = busy_q;
    left_d = left_q;
    if (start) begin
      busy_d = 1'b1;
      left_d = CW'(W);
    end else if (busy_q && rise_tick) begin
      left_d = left_q - 1'b1;
      if (left_q == CW'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      left_q <= left_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  output logic         sdo
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = word;
      cnt_d = CW'(W);
    end else if (shift && cnt_q != '0) begin
      sh_d  = {sh_q[W-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign sdo = (cnt_q != '0) & sh_q[W-1];
endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
  import adc_serial_if_pkg::*;
#(
  parameter int unsigned W   = SAMPLE_W,
  parameter int unsigned DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_n,
  input  logic         rd_n,
  input  logic [1:0]   pwr_mode,
  input  logic         clk_sel,
  input  logic         after_mode,
  input  logic         ext_sclk,
  input  logic [W-1:0] sample_i,
  output logic         busy_n,
  output logic         clkout,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         ctl_oe
);
  logic rise_tick, ext_rise, start, busy;
  logic shift_pulse, shift_ok, shift;
  logic asleep;

  adc_clkgen #(.DIV(DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .clkout(clkout), .rise_tick(rise_tick)
  );

  adc_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_sclk), .rise(ext_rise)
  );

  adc_conv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(~conv_n),
    .run_ok(pwr_is_run(pwr_mode)), .rise_tick(rise_tick),
    .start(start), .busy(busy)
  );

  always_comb begin
    asleep      = pwr_is_sleep(pwr_mode);
    shift_pulse = clk_sel ? ext_rise : rise_tick;
    shift_ok    = ~asleep & (after_mode ? (~busy & ~rd_n) : busy);
    shift       = shift_pulse & shift_ok;
  end

  adc_shift_out #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .word(sample_i),
    .shift(shift), .sdo(sdo)
  );

  assign busy_n = ~busy;
  assign sdo_oe = ~rd_n & ~asleep;
  assign ctl_oe = ~asleep;
endmodule

// File: rtl/adc_serial_if_chk.sv
module adc_serial_if_chk #(
  parameter int unsigned DIV = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_n,
  input logic       rd_n,
  input logic [1:0] pwr_mode,
  input logic       after_mode,
  input logic       busy_n,
  input logic       clkout,
  input logic       sdo,
  input logic       sdo_oe,
  input logic       ctl_oe
);
  localparam int unsigned KW = $clog2(DIV + 2);

  logic          prev_clk, seen;
  logic [KW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      seen     <= 1'b0;
      since    <= '0;
    end else begin
      prev_clk <= clkout;
      if (clkout != prev_clk) begin
        seen  <= 1'b1;
        since <= '0;
      end else if (since != {KW{1'b1}}) begin
        since <= since + 1'b1;
      end
    end
  end

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(!conv_n)); // R2
  AST_START_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> ($past(pwr_mode) == 2'b00)); // R8
  AST_SLEEP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode[1] |-> (!sdo_oe && !ctl_oe)); // R9
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !sdo_oe); // R10
  AST_HOLD_UNTIL_RD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(after_mode) && $past(rd_n) && $past(conv_n)) |-> $stable(sdo)); // R7
  AST_CLKOUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((clkout != prev_clk) == (since == KW'(DIV - 1)))); // R11
endmodule

bind adc_serial_if adc_serial_if_chk #(.DIV(DIV)) u_chk (.*);

// File: tb/adc_serial_if_bench.sv
module adc_serial_if_bench;
  localparam int W = 14;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_n = 1'b1, rd_n = 1'b1, clk_sel = 1'b0, after_mode = 1'b0, ext_sclk = 1'b0;
  logic [1:0] pwr_mode = 2'b00;
  logic [W-1:0] sample_i = '0;
  logic busy_n, clkout, sdo, sdo_oe, ctl_oe;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_serial_if u_adc_serial_if (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .rd_n(rd_n), .pwr_mode(pwr_mode),
    .clk_sel(clk_sel), .after_mode(after_mode), .ext_sclk(ext_sclk),
    .sample_i(sample_i), .busy_n(busy_n), .clkout(clkout), .sdo(sdo),
    .sdo_oe(sdo_oe), .ctl_oe(ctl_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_div = 0, m_left = 0, m_bits = 0;
  bit m_clk = 0, m_busy = 0, s0 = 0, s1 = 0, s2 = 0;
  logic [W-1:0] m_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_left = 0; m_bits = 0; m_clk = 0; m_busy = 0;
      s0 = 0; s1 = 0; s2 = 0; m_data = '0;
    end else begin
      bit er, tk, rt, st, ok, sp;
      er = s1 && !s2;
      s2 = s1; s1 = s0; s0 = ext_sclk;
      tk = (m_div == DIV - 1);
      rt = tk && !m_clk;
      st = !conv_n && !m_busy && (pwr_mode == 2'b00);
      sp = clk_sel ? er : rt;
      ok = !pwr_mode[1] && (after_mode ? (!m_busy && !rd_n) : m_busy);
      if (st) begin
        m_data = sample_i; m_bits = W; m_busy = 1; m_left = W;
      end else begin
        if (sp && ok && m_bits > 0) begin
          m_data = m_data << 1; m_bits--;
        end
        if (m_busy && rt) begin
          m_left--;
          if (m_left == 0) m_busy = 0;
        end
      end
      m_div = tk ? 0 : m_div + 1;
      if (tk) m_clk = !m_clk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_sdo;
      e_sdo = (m_bits > 0) ? m_data[W-1] : 1'b0;
      chk(busy_n == !m_busy, "R2 busy_n", busy_n, !m_busy);
      chk(sdo == e_sdo, "R4 R5 R6 sdo", sdo, e_sdo);
      chk(clkout == m_clk, "R11 clkout", clkout, m_clk);
      chk(sdo_oe == (!rd_n && !pwr_mode[1]), "R10 sdo_oe", sdo_oe, !rd_n && !pwr_mode[1]);
      chk(ctl_oe == !pwr_mode[1], "R9 ctl_oe", ctl_oe, !pwr_mode[1]);
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      chk(0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  task automatic pulse_start();
    @(negedge clk); #1 conv_n = 1'b0;
    @(negedge clk); #1 conv_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (busy_n) break;
    end
  endtask

  task automatic read_ext_word(output logic [W-1:0] w);
    w = '0;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      w = {w[W-2:0], sdo};
      #1 ext_sclk = 1'b1;
      repeat (3) @(negedge clk);
      #1 ext_sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    logic [W-1:0] got;
    int low_cnt;
    repeat (3) @(negedge clk);
    chk(busy_n == 1'b1, "R1 busy_n in reset", busy_n, 1);
    chk(sdo == 1'b0, "R1 sdo in reset", sdo, 0);
    chk(clkout == 1'b0, "R1 clkout in reset", clkout, 0);
    #1 rst_n = 1'b1;

    // R5: during conversion, internal clock
    rd_n = 1'b0; sample_i = 14'h2A5C;
    pulse_start();
    low_cnt = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (busy_n) break;
      low_cnt++;
    end
    chk(low_cnt >= 14 * 2 * DIV - 2 * DIV && low_cnt <= 14 * 2 * DIV + 1,
        "R2 busy length", low_cnt, 14 * 2 * DIV);
    repeat (10) @(negedge clk);
    chk(sdo == 1'b0, "R4 sdo after word", sdo, 0);

    // R6: during conversion, external clock
    #1 clk_sel = 1'b1; sample_i = 14'h1C63;
    pulse_start();
    for (int i = 0; i < 5; i++) begin
      #1 ext_sclk = 1'b1; repeat (3) @(negedge clk);
      #1 ext_sclk = 1'b0; repeat (3) @(negedge clk);
    end
    wait_idle();

    // R7: after-conversion, external clock, held until read
    #1 after_mode = 1'b1; rd_n = 1'b1; sample_i = 14'h1F3B;
    pulse_start();
    wait_idle();
    repeat (20) @(negedge clk);
    #1 rd_n = 1'b0;
    read_ext_word(got);
    chk(got == 14'h1F3B, "R7 R6 word read after conversion", got, 14'h1F3B);
    @(negedge clk);
    chk(sdo == 1'b0, "R4 sdo low after 14 bits", sdo, 0);

    // R3: start during busy ignored
    #1 rd_n = 1'b1; sample_i = 14'h0F0F;
    pulse_start();
    repeat (6) @(negedge clk);
    #1 sample_i = 14'h3333; conv_n = 1'b0;
    @(negedge clk); #1 conv_n = 1'b1;
    wait_idle();
    #1 rd_n = 1'b0;
    read_ext_word(got);
    chk(got == 14'h0F0F, "R3 second start ignored", got, 14'h0F0F);

    // R8: nap keeps readout and refuses starts
    #1 rd_n = 1'b1; sample_i = 14'h2D71;
    pulse_start();
    wait_idle();
    #1 pwr_mode = 2'b01; sample_i = 14'h0001; conv_n = 1'b0;
    low_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!busy_n) low_cnt++;
    end
    chk(low_cnt == 0, "R8 no start in nap", low_cnt, 0);
    #1 conv_n = 1'b1; rd_n = 1'b0;
    read_ext_word(got);
    chk(got == 14'h2D71, "R8 word read in nap", got, 14'h2D71);

    // R9: sleep releases outputs, keeps word
    #1 pwr_mode = 2'b00; rd_n = 1'b1; sample_i = 14'h15AA;
    pulse_start();
    wait_idle();
    #1 pwr_mode = 2'b10; rd_n = 1'b0; conv_n = 1'b0;
    repeat (12) @(negedge clk);
    chk(sdo_oe == 1'b0, "R9 sdo_oe in sleep", sdo_oe, 0);
    chk(ctl_oe == 1'b0, "R9 ctl_oe in sleep", ctl_oe, 0);
    chk(busy_n == 1'b1, "R9 no start in sleep", busy_n, 1);
    #1 conv_n = 1'b1; rd_n = 1'b1; pwr_mode = 2'b00;
    @(negedge clk); #1 rd_n = 1'b0;
    read_ext_word(got);
    chk(got == 14'h15AA, "R9 word kept through sleep", got, 14'h15AA);

    // R7 R5: after-conversion, internal clock
    #1 clk_sel = 1'b0; rd_n = 1'b1; sample_i = 14'h3ABC;
    pulse_start();
    wait_idle();
    repeat (8) @(negedge clk);
    chk(sdo == 1'b1, "R7 MSB held before read", sdo, 1);
    #1 rd_n = 1'b0;
    repeat (80) @(negedge clk);
    chk(sdo == 1'b0, "R5 word drained", sdo, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule